// File: doc/BRIEF.md
# Table-Linearized Threshold Trip Channel

This block turns one sampled analogue measurement into a binary protection trip request. ADC codes arrive with a valid strobe. They are summed over a fixed window of samples (a boxcar average) and the sum is cleared at the start of every window. Choose the sample rate so that the window spans a whole number of both 50 Hz and 60 Hz periods, for example 100 ms; mains pickup then averages out.

The averaged code addresses a characteristic table. Each table entry holds the already linearized and compensated engineering value for that code, so the table alone sets the input's range and curve. The table value is compared with a programmable threshold. The trip sets at or above the threshold and clears only once the value has fallen a programmable hysteresis margin below it. A sample at either end of the ADC range marks the window as out of range, and that forces the trip.

The table, threshold and hysteresis are loaded through a simple write port at configuration time. A hardware lock input blocks all writes during normal operation, and any write tried while locked is recorded in a sticky status bit.

Top module: `trip_chan`

## Requirements
- R1: While reset is low and just after it is released, `trip`, `value_out`, `value_valid`, `oor_flag` and `wr_viol` are all zero.
- R2: Every WIN_LEN samples taken with `smp_valid` high form one window. The averaged code is floor(sum of the window's codes / WIN_LEN). Cycles with `smp_valid` low do not contribute.
- R3: `value_valid` pulses high for one cycle, two rising edges after the edge that accepts the last sample of a window. In that cycle `value_out` equals the table entry addressed by the window's averaged code.
- R4: When a window's table value is greater than or equal to the threshold, `trip` becomes 1 in the same cycle that `value_valid` pulses.
- R5: When a window's table value plus the hysteresis is less than the threshold, `trip` becomes 0. A value between those bounds leaves `trip` unchanged. `trip` changes only in a cycle where `value_valid` is high.
- R6: If any sample of a window has code 0 or code 2^CODE_W-1, then `oor_flag` is 1 and `trip` is 1 for that window's result, whatever the table value.
- R7: The accumulator, sample count and out-of-range flag restart from zero at each window. A clean window that follows an out-of-range window gets `oor_flag` = 0 and a trip decided by its own value only.
- R8: With `cfg_lock` low, a cycle with `cfg_we` high writes `cfg_data` to the item chosen by `cfg_sel`: 0 is the table entry at `cfg_addr`, 1 is the threshold, 2 is the hysteresis, and 3 writes nothing.
- R9: With `cfg_lock` high, a write leaves the table, threshold and hysteresis unchanged and sets `wr_viol` on the next edge. `wr_viol` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | ADC sample strobe |
| smp_code | input | CODE_W | ADC code |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Write target: 0 table, 1 threshold, 2 hysteresis |
| cfg_addr | input | CODE_W | Table entry address |
| cfg_data | input | VAL_W | Write data |
| cfg_lock | input | 1 | Hardware write lock |
| trip | output | 1 | Trip request |
| value_out | output | VAL_W | Table value of the last window |
| value_valid | output | 1 | One-cycle pulse marking a new result |
| oor_flag | output | 1 | The last window held an end-of-range code |
| wr_viol | output | 1 | Sticky flag for a write attempted while locked |

## Verification
The bench sweeps a value through the three regions of the hysteresis band. A comparator with no band would drop the trip too early inside the band, and one with a wrong bound would never release it. It injects a single code 0 and a single full-scale code into otherwise ordinary windows, then follows each with a clean window. A design that forgot the range check would leave the trip off, and one that did not clear its flag per window would keep forcing the trip. Random windows with idle gaps catch miscounted windows or a sum that is not restarted. Writes made under the lock are followed by a window that reads back the entry they aimed at, so a leaky lock shows up as a changed value or a changed trip decision.

// File: rtl/trip_chan_pkg.sv
package trip_chan_pkg;
   typedef enum logic [1:0] {
      CFG_TABLE  = 2'd0,
      CFG_THRESH = 2'd1,
      CFG_HYST   = 2'd2,
      CFG_NONE   = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/trip_avg.sv
// Boxcar averager: sums WIN_LEN valid samples, emits one result, restarts.
module trip_avg #(
   parameter int CODE_W  = 8,
   parameter int WIN_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_code,
   output logic              avg_valid,
   output logic [CODE_W-1:0] avg_code,
   output logic              avg_oor
);
   localparam int SHIFT = $clog2(WIN_LEN);
   localparam int ACC_W = CODE_W + SHIFT;
   localparam int CNT_W = (SHIFT > 0) ? SHIFT : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

   initial begin
      assert (WIN_LEN > 0 && (WIN_LEN & (WIN_LEN - 1)) == 0)
         else $error("WIN_LEN must be a power of two");
      assert (CODE_W >= 2) else $error("CODE_W too small");
   end

   logic [ACC_W-1:0] acc_q, sum_next;
   logic [CNT_W-1:0] cnt_q;
   logic             oor_q, edge_hit;

   assign sum_next = acc_q + ACC_W'(in_code);
   assign edge_hit = (in_code == '0) || (in_code == {CODE_W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q     <= '0;
         cnt_q     <= '0;
         oor_q     <= 1'b0;
         avg_valid <= 1'b0;
         avg_code  <= '0;
         avg_oor   <= 1'b0;
      end else begin
         avg_valid <= 1'b0;
         if (in_valid) begin
            if (cnt_q == LAST) begin
               avg_code  <= sum_next[ACC_W-1:SHIFT];
               avg_oor   <= oor_q | edge_hit;
               avg_valid <= 1'b1;
               acc_q     <= '0;
               cnt_q     <= '0;
               oor_q     <= 1'b0;
            end else begin
               acc_q <= sum_next;
               cnt_q <= cnt_q + 1'b1;
               oor_q <= oor_q | edge_hit;
            end
         end
      end
   end
endmodule

// File: rtl/trip_lut.sv
// Characteristic table: one stored value per code, code is the address.
module trip_lut #(
   parameter int CODE_W = 8,
   parameter int VAL_W  = 12
) (
   input  logic              clk,
   input  logic              we,
   input  logic [CODE_W-1:0] waddr,
   input  logic [VAL_W-1:0]  wdata,
   input  logic [CODE_W-1:0] raddr,
   output logic [VAL_W-1:0]  rdata
);
   localparam int DEPTH = 1 << CODE_W;

   logic [VAL_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/trip_cmp.sv
// Threshold comparator with hysteresis and optional out-of-range force.
module trip_cmp #(
   parameter int VAL_W    = 12,
   parameter bit OOR_TRIP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VAL_W-1:0] in_val,
   input  logic             in_oor,
   input  logic [VAL_W-1:0] thr,
   input  logic [VAL_W-1:0] hys,
   output logic             trip,
   output logic [VAL_W-1:0] val_q,
   output logic             val_valid,
   output logic             oor_q
);
   logic at_or_above, below_band, force_trip;

   assign at_or_above = (in_val >= thr);
   assign below_band  = ({1'b0, in_val} + {1'b0, hys}) < {1'b0, thr};

   generate
      if (OOR_TRIP) begin : g_force
         assign force_trip = in_oor;
      end else begin : g_noforce
         assign force_trip = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trip      <= 1'b0;
         val_q     <= '0;
         val_valid <= 1'b0;
         oor_q     <= 1'b0;
      end else begin
         val_valid <= in_valid;
         if (in_valid) begin
            val_q <= in_val;
            oor_q <= in_oor;
            if (force_trip || at_or_above) trip <= 1'b1;
            else if (below_band)          trip <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/trip_chan.sv
module trip_chan
   import trip_chan_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int VAL_W    = 12,
   parameter int WIN_LEN  = 16,
   parameter bit OOR_TRIP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [CODE_W-1:0] smp_code,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CODE_W-1:0] cfg_addr,
   input  logic [VAL_W-1:0]  cfg_data,
   input  logic              cfg_lock,
   output logic              trip,
   output logic [VAL_W-1:0]  value_out,
   output logic              value_valid,
   output logic              oor_flag,
   output logic              wr_viol
);
   cfg_sel_e          sel;
   logic              wr_ok;
   logic [VAL_W-1:0]  thr_q, hys_q, tbl_val;
   logic              avg_valid, avg_oor;
   logic [CODE_W-1:0] avg_code;

   assign sel   = cfg_sel_e'(cfg_sel);
   assign wr_ok = cfg_we && !cfg_lock;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q   <= '0;
         hys_q   <= '0;
         wr_viol <= 1'b0;
      end else begin
         if (cfg_we && cfg_lock) wr_viol <= 1'b1;
         if (wr_ok && sel == CFG_THRESH) thr_q <= cfg_data;
         if (wr_ok && sel == CFG_HYST)   hys_q <= cfg_data;
      end
   end

   trip_avg #(.CODE_W(CODE_W), .WIN_LEN(WIN_LEN)) i_avg (
      .clk(clk), .rst_n(rst_n), .in_valid(smp_valid), .in_code(smp_code),
      .avg_valid(avg_valid), .avg_code(avg_code), .avg_oor(avg_oor)
   );

   trip_lut #(.CODE_W(CODE_W), .VAL_W(VAL_W)) i_lut (
      .clk(clk), .we(wr_ok && sel == CFG_TABLE), .waddr(cfg_addr),
      .wdata(cfg_data), .raddr(avg_code), .rdata(tbl_val)
   );

   trip_cmp #(.VAL_W(VAL_W), .OOR_TRIP(OOR_TRIP)) i_cmp (
      .clk(clk), .rst_n(rst_n), .in_valid(avg_valid), .in_val(tbl_val),
      .in_oor(avg_oor), .thr(thr_q), .hys(hys_q), .trip(trip),
      .val_q(value_out), .val_valid(value_valid), .oor_q(oor_flag)
   );
endmodule

// File: rtl/trip_chan_chk.sv
module trip_chan_chk #(
   parameter int VAL_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic             cfg_lock,
   input logic [VAL_W-1:0] thr_q,
   input logic             avg_valid,
   input logic             avg_oor,
   input logic             trip,
   input logic             value_valid,
   input logic             oor_flag,
   input logic             wr_viol
);
   assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_viol |=> wr_viol);
   assert_locked_sets_viol_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_lock) |=> wr_viol);
   assert_locked_thr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_lock) |=> $stable(thr_q));
   assert_oor_forces_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_valid && avg_oor) |=> (trip && oor_flag));
   assert_result_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      avg_valid |=> value_valid);
   assert_trip_moves_on_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(trip) |-> value_valid);
endmodule

bind trip_chan trip_chan_chk #(.VAL_W(VAL_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lock(cfg_lock),
   .thr_q(thr_q), .avg_valid(avg_valid), .avg_oor(avg_oor), .trip(trip),
   .value_valid(value_valid), .oor_flag(oor_flag), .wr_viol(wr_viol)
);

// File: tb/test_trip_chan.sv
module test_trip_chan;
   localparam int CLK_PERIOD = 10;
   localparam int CODE_W = 8;
   localparam int VAL_W = 12;
   localparam int WIN_LEN = 16;
   localparam int DEPTH = 1 << CODE_W;
   localparam int CODE_MAX = DEPTH - 1;

   logic clk = 1'b0;
   logic rst_n;
   logic smp_valid;
   logic [CODE_W-1:0] smp_code;
   logic cfg_we;
   logic [1:0] cfg_sel;
   logic [CODE_W-1:0] cfg_addr;
   logic [VAL_W-1:0] cfg_data;
   logic cfg_lock;
   logic trip, value_valid, oor_flag, wr_viol;
   logic [VAL_W-1:0] value_out;

   int checks = 0;
   int errors = 0;
   int tbl [DEPTH];
   int m_thr = 0, m_hys = 0, m_trip = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trip_chan i_trip_chan (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .cfg_lock(cfg_lock), .trip(trip), .value_out(value_out),
      .value_valid(value_valid), .oor_flag(oor_flag), .wr_viol(wr_viol)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input int sel, input int addr, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_addr = addr[CODE_W-1:0];
      cfg_data = data[VAL_W-1:0];
      if (!cfg_lock) begin
         if (sel == 0) tbl[addr] = data;
         if (sel == 1) m_thr = data;
         if (sel == 2) m_hys = data;
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // mode 0: constant target; 1: random; 2: one code 0; 3: one full-scale code
   task automatic run_window(input string tag, input int mode, input int target);
      int sum = 0;
      int oor = 0;
      int avg, val;
      for (int i = 0; i < WIN_LEN; i++) begin
         int c;
         if ($urandom % 4 == 0) begin
            @(negedge clk);
            smp_valid = 1'b0; smp_code = CODE_W'($urandom);
         end
         c = (mode == 1) ? 1 + int'($urandom % (CODE_MAX - 1)) : target;
         if (mode == 2 && i == 5) c = 0;
         if (mode == 3 && i == 9) c = CODE_MAX;
         if (c == 0 || c == CODE_MAX) oor = 1;
         sum += c;
         @(negedge clk);
         smp_valid = 1'b1; smp_code = c[CODE_W-1:0];
      end
      @(negedge clk);
      smp_valid = 1'b0;
      @(negedge clk);
      avg = sum / WIN_LEN;
      val = tbl[avg];
      if (oor != 0 || val >= m_thr) m_trip = 1;
      else if (val + m_hys < m_thr) m_trip = 0;
      chk({tag, " R3 value_valid"}, int'(value_valid), 1);
      chk({tag, " R2 R3 value_out"}, int'(value_out), val);
      chk({tag, " R4 R5 trip"}, int'(trip), m_trip);
      chk({tag, " R6 R7 oor_flag"}, int'(oor_flag), oor);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd5531));
      rst_n = 1'b0; smp_valid = 1'b0; smp_code = '0; cfg_we = 1'b0;
      cfg_sel = '0; cfg_addr = '0; cfg_data = '0; cfg_lock = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 trip in reset", int'(trip), 0);
      chk("R1 value_out in reset", int'(value_out), 0);
      chk("R1 value_valid in reset", int'(value_valid), 0);
      chk("R1 oor_flag in reset", int'(oor_flag), 0);
      chk("R1 wr_viol in reset", int'(wr_viol), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 trip after reset", int'(trip), 0);

      // R8: load table, threshold, hysteresis
      for (int a = 0; a < DEPTH; a++) cfg_write(0, a, int'($urandom % (1 << VAL_W)));
      cfg_write(0, 10, 1000);
      cfg_write(0, 20, 800);
      cfg_write(0, 30, 500);
      cfg_write(1, 0, 900);
      cfg_write(2, 0, 200);
      cfg_write(3, 0, 4095);
      chk("R1 R8 no trip before first window", int'(trip), 0);

      // R4 R5: walk through hysteresis band
      run_window("R4 set", 0, 10);
      run_window("R5 hold in band", 0, 20);
      run_window("R5 clear below band", 0, 30);
      run_window("R5 stay clear in band", 0, 20);
      run_window("R4 set again", 0, 10);
      run_window("R5 clear", 0, 30);

      // R6 R7: end-of-range codes and per-window restart
      run_window("R6 low code", 2, 30);
      run_window("R7 clean after low", 0, 30);
      run_window("R6 high code", 3, 30);
      run_window("R7 clean after high", 0, 30);

      // R2 R8: random windows, threshold changes
      for (int k = 0; k < 40; k++) begin
         if (k % 10 == 0) begin
            cfg_write(1, 0, int'($urandom % (1 << VAL_W)));
            cfg_write(2, 0, int'($urandom % 512));
         end
         run_window("R2 random", 1, 0);
      end

      // R9: locked writes ignored, sticky violation flag
      cfg_write(1, 0, 900);
      cfg_write(2, 0, 200);
      run_window("R9 prep clear", 0, 30);
      cfg_lock = 1'b1;
      cfg_write(0, 30, 3000);
      chk("R9 wr_viol set", int'(wr_viol), 1);
      cfg_write(1, 0, 0);
      run_window("R9 locked table/threshold unchanged", 0, 30);
      cfg_lock = 1'b0;
      run_window("R9 after unlock", 0, 10);
      chk("R9 wr_viol sticky", int'(wr_viol), 1);
      cfg_write(0, 40, 7);
      chk("R9 wr_viol stays", int'(wr_viol), 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule